// File: doc/BRIEF.md
# Two-Pin Digital I/O Port with Edge-Triggered Secondary Functions

This block runs two bidirectional digital pins behind a pair of 32-bit registers: a data register and a control register. The control register gives each pin its own direction. It also enables a set of secondary input functions. Each of these functions watches one pin for a chosen edge and emits a one-cycle event pulse. The functions are:

- a conversion trigger,
- a conversion start,
- a converter load,
- two general external interrupts.

Each event pulse is also offered as an interrupt-request pulse. A per-function enable that comes from outside the block gates that request.

One output secondary function hands pin 1 over to a watchdog status level. When it is on, it overrides that pin's direction bit. Pin inputs are synchronised before any edge detection or readback. The register port is a plain write strobe plus a select line, with a combinational read path.

Top module: `dio2_top`

## Requirements
- R1: After reset both pins are inputs (`pin_oe`=00), `pin_out`=00, `evt` and `irq` are zero, and the control register reads 0.
- R2: A data write (`reg_sel`=0) stores `reg_wdata[1:0]` as the pin output latch, bit 0 for pin 0 and bit 1 for pin 1. `pin_out` shows the latch from the next cycle, and data bits 31..2 always read as 0.
- R3: A data read returns the following for each pin: the output latch when the pin is an output, or the pin level sampled through a two-flop synchroniser when it is an input. A new input level reads back two clock edges after it changes.
- R4: Control bits 0 and 1 set the direction of pin 0 and pin 1 (1 = output, 0 = input), and they appear on `pin_oe` from the next cycle.
- R5: The control register keeps only bits 1..0 and 26..16. Every other bit is dropped on write and reads as 0.
- R6: Function k (k = 0..4) is enabled by control bit 16+2k, and its edge select is bit 17+2k. The functions in index order are trigger, start, load, ext0 and ext1, and `evt[k]`/`irq[k]` use the same index. Trigger, start and ext0 watch pin 0. Load and ext1 watch pin 1.
- R7: An edge-select bit of 1 picks the rising edge and 0 picks the falling edge. An edge of the other polarity gives no pulse.
- R8: Each qualifying edge gives exactly one `evt` pulse, one cycle wide. It appears after the third rising clock edge that follows the pin change.
- R9: A function whose enable bit is 0 never pulses, whatever its pin does.
- R10: `irq[k]` rises together with `evt[k]` only if `irq_en[k]` was 1 in the cycle before the pulse. Otherwise `irq[k]` stays 0.
- R11: With control bit 26 set, `pin_oe[1]`=1 and `pin_out[1]` follows `wdog_status`, whatever control bit 1 and data bit 1 hold. Data bit 1 then reads back as `wdog_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pin_in | input | 2 | Pin input levels (asynchronous) |
| pin_out | output | 2 | Pin drive levels |
| pin_oe | output | 2 | Pin output enables |
| wdog_status | input | 1 | Watchdog status level shown on pin 1 |
| irq_en | input | 5 | Per-function interrupt-request enables |
| evt | output | 5 | Per-function event pulses |
| irq | output | 5 | Per-function interrupt-request pulses |

## Verification
The bench goes after the following corner cases:

- **Edge of the wrong polarity on an enabled function.** A detector that ignores the select bit would add a pulse here.
- **Edge on a pin whose functions are disabled.** An enable that is dropped or mis-wired would leak pulses.
- **A function mapped to the wrong pin.** This shows up as a pulse on the wrong index.
- **Wrong pulse timing or width.** A pulse one cycle early or late, or two cycles wide, breaks the cycle-exact scoreboard match.
- **Control writes with every bit set.** A wrong register mask shows up in readback.
- **Watchdog override with data bit 1 left at 1 and status at 0.** This exposes a mux that lets the latch win.

// File: rtl/dio2_pkg.sv
package dio2_pkg;
    localparam int NPIN         = 2;
    localparam int NFN          = 5;
    localparam int CTRL_FN_BASE = 16;
    localparam int WDOG_BIT     = 26;

    localparam int FN_TRIG  = 0;
    localparam int FN_START = 1;
    localparam int FN_LOAD  = 2;
    localparam int FN_EXT0  = 3;
    localparam int FN_EXT1  = 4;

    // pin watched by each secondary input function
    function automatic int fn_pin(input int k);
        return (k == FN_LOAD || k == FN_EXT1) ? 1 : 0;
    endfunction

    // writable control bits
    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < NPIN; i++) m[i] = 1'b1;
        for (int i = 0; i < 2*NFN; i++) m[CTRL_FN_BASE+i] = 1'b1;
        m[WDOG_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/dio2_sync.sv
module dio2_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q      = st_q.s2;
    assign q_prev = st_q.s3;
endmodule

// File: rtl/dio2_edge.sv
module dio2_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic en,
    input  logic rise_sel,
    input  logic irq_en,
    output logic evt,
    output logic irq
);
    typedef struct packed {
        logic evt;
        logic irq;
    } edge_t;

    edge_t e_d, e_q;
    logic  hit;

    always_comb begin
        hit   = rise_sel ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);
        e_d.evt = en & hit;
        e_d.irq = en & hit & irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign evt = e_q.evt;
    assign irq = e_q.irq;
endmodule

// File: rtl/dio2_top.sv
module dio2_top
    import dio2_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    input  logic            wdog_status,
    input  logic [NFN-1:0]  irq_en,
    output logic [NFN-1:0]  evt,
    output logic [NFN-1:0]  irq
);
    localparam logic [DW-1:0] CTRL_MASK = DW'(ctrl_mask());

    typedef struct packed {
        logic [DW-1:0]   ctrl;
        logic [NPIN-1:0] dout;
    } regs_t;

    regs_t           r_d, r_q;
    logic [NPIN-1:0] lvl, lvl_prev;
    logic [NPIN-1:0] oe_eff, out_eff, rd_bits;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            if (reg_sel) r_d.ctrl = reg_wdata & CTRL_MASK;
            else         r_d.dout = reg_wdata[NPIN-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // pin 1 handover to watchdog status
    always_comb begin
        oe_eff  = r_q.ctrl[NPIN-1:0];
        out_eff = r_q.dout;
        if (r_q.ctrl[WDOG_BIT]) begin
            oe_eff[1]  = 1'b1;
            out_eff[1] = wdog_status;
        end
        for (int p = 0; p < NPIN; p++)
            rd_bits[p] = oe_eff[p] ? out_eff[p] : lvl[p];
        reg_rdata = reg_sel ? r_q.ctrl : {{(DW-NPIN){1'b0}}, rd_bits};
    end

    assign pin_oe  = oe_eff;
    assign pin_out = out_eff;

    dio2_sync #(.W(NPIN)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (lvl),
        .q_prev (lvl_prev)
    );

    for (genvar k = 0; k < NFN; k++) begin : g_fn
        localparam int PIN = fn_pin(k);
        dio2_edge edge_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[PIN]),
            .lvl_prev (lvl_prev[PIN]),
            .en       (r_q.ctrl[CTRL_FN_BASE+2*k]),
            .rise_sel (r_q.ctrl[CTRL_FN_BASE+2*k+1]),
            .irq_en   (irq_en[k]),
            .evt      (evt[k]),
            .irq      (irq[k])
        );
    end
endmodule

// File: rtl/dio2_chk.sv
module dio2_chk
    import dio2_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic [31:0]     reg_wdata,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic            wdog_status,
    input logic [NFN-1:0]  irq_en,
    input logic [NFN-1:0]  evt,
    input logic [NFN-1:0]  irq
);
    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & $past(evt)) == '0);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (evt & $past(irq_en)));

    // R2
    data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> pin_out[0] == $past(reg_wdata[0]));

    // R4
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && !reg_wdata[WDOG_BIT]) |=> pin_oe == $past(reg_wdata[NPIN-1:0]));

    // R11
    wdog_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[WDOG_BIT]) |=> (pin_oe[1] && pin_out[1] == wdog_status));
endmodule

bind dio2_top dio2_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .wdog_status (wdog_status),
    .irq_en      (irq_en),
    .evt         (evt),
    .irq         (irq)
);

// File: tb/dio2_top_tb_top.sv
module dio2_top_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic        reg_sel = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pin_in = '0;
    logic [1:0]  pin_out, pin_oe;
    logic        wdog_status = 0;
    logic [4:0]  irq_en = '0;
    logic [4:0]  evt, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [31:0] ctrl_m = '0;
    bit done = 0;

    typedef struct { int cyc; logic [4:0] evt; logic [4:0] irq; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dio2_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .wdog_status(wdog_status),
        .irq_en(irq_en), .evt(evt), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (sel) ctrl_m = d & 32'h07FF_0003;
    endtask

    task automatic rd(input logic sel, input logic [31:0] expv, input string tag);
        @(negedge clk);
        reg_sel = sel;
        #1 check(tag, reg_rdata, expv);
    endtask

    // driver: change one pin, predict events from the control model
    task automatic pin_set(input int p, input logic v);
        logic [4:0] m;
        logic old;
        @(negedge clk);
        old = pin_in[p];
        m = '0;
        for (int k = 0; k < 5; k++) begin
            int fp;
            fp = (k == 2 || k == 4) ? 1 : 0;
            if (fp == p && ctrl_m[16+2*k] && old != v &&
                (ctrl_m[17+2*k] ? v : !v)) m[k] = 1'b1;
        end
        pin_in[p] = v;
        if (m != 0) exp_q.push_back('{cyc + 3, m, m & irq_en});
        repeat (6) @(negedge clk);
    endtask

    // monitor: R6 R7 R8 R9 R10 compared cycle-exactly
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() != 0 && exp_q[0].cyc == cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R8 evt", {27'd0, evt}, {27'd0, e.evt});
                check("R10 irq", {27'd0, irq}, {27'd0, e.irq});
            end else if (evt != 0 || irq != 0) begin
                check("R9 stray evt", {22'd0, evt, irq}, 32'd0);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                #1;
                check("R1 oe", {30'd0, pin_oe}, 0);
                check("R1 out", {30'd0, pin_out}, 0);
                check("R1 evt", {22'd0, evt, irq}, 0);
                rd(1, 0, "R1 ctrl");

                wr(0, 32'hFFFF_FFFE);
                wr(1, 32'h0000_0003);
                rd(0, 32'h2, "R2 R3 data readback out");
                check("R2 pin_out", {30'd0, pin_out}, 2);
                check("R4 pin_oe", {30'd0, pin_oe}, 3);

                wr(1, 32'hFBFF_FFFF);
                rd(1, 32'h03FF_0003, "R5 ctrl mask");

                wr(1, 32'h0);
                check("R4 inputs", {30'd0, pin_oe}, 0);
                pin_set(0, 1);
                rd(0, 32'h1, "R3 input level");

                // R6 R7 rising on all, irq partly enabled
                irq_en = 5'b10101;
                wr(1, 32'h03FF_0000);
                pin_set(0, 0);          // falling: no pulse (R7)
                pin_set(0, 1);          // trig start ext0
                pin_set(1, 1);          // load ext1
                irq_en = 5'b01010;
                pin_set(1, 0);          // falling: none

                // falling on all
                wr(1, 32'h0155_0000);
                pin_set(1, 1);
                pin_set(1, 0);          // load ext1
                pin_set(0, 0);          // trig start ext0

                // R9 only start enabled, falling
                wr(1, 32'h0004_0000);
                pin_set(1, 1);
                pin_set(0, 1);
                pin_set(0, 0);          // start only
                pin_set(1, 0);

                // R11 watchdog handover
                wr(0, 32'h2);
                wdog_status = 1;
                wr(1, 32'h0400_0000);
                check("R11 oe", {30'd0, pin_oe}, 2);
                check("R11 out hi", {31'd0, pin_out[1]}, 1);
                wdog_status = 0;
                rd(0, 32'h0, "R11 readback low");
                check("R11 out lo", {31'd0, pin_out[1]}, 0);

                repeat (5) @(negedge clk);
                check("R8 missing events", exp_q.size(), 0);
            end
            begin
                repeat (5000) @(posedge clk);
                check("watchdog expired", 1, 0);
            end
        join_any
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule